// File: doc/BRIEF.md
# Reset Pulse Duration Counter

The block measures how long an external active-low reset pin stays low. Time is counted in cycles of the 25 MHz reference clock on which the block runs, so one count is 40 ns and one second is 25,000,000 counts. The pin is asynchronous to that clock and first passes through a two-flop synchronizer. While the synchronized pin is low, a saturating counter advances by one per clock. It stops at its all-ones value and does not wrap. After the pin is released the counter keeps its value, so software can read later how long the last press lasted. The count therefore reflects the most recent assertion, because each new falling edge of the synchronized pin restarts it from zero.

Software reaches the counter through one 32-bit register at offset 0x50 of the block's register window. The register uses a plain request strobe with a write flag. The block accepts a request in every cycle and never applies back-pressure. A read always produces a response one cycle later with no ready signal on either side, and a write produces no response. Writing the clear bit forces the counter to zero. Only the separate power-on reset and that clear bit reset the counter; the measured pin never does.

Top module: `pin_hold_meter`

## Requirements
- R1: While the synchronized pin is low, the count increases by exactly one per clock. A press seen by the pin on L consecutive rising edges yields a count of L, and the pin takes two extra cycles to reach the counter through the synchronizer.
- R2: While the synchronized pin is high and no clear is written, the count holds its value, so a finished press stays readable.
- R3: At 2^CNT_W−1 (2^29−1 with the default width, about 21.4 s) the count stays at that value while the pin remains low and does not wrap.
- R4: A new high-to-low transition of the synchronized pin restarts the count from zero, so the first low cycle of the new press gives a count of 1.
- R5: A write to offset 0x50 with bit 31 set clears the count to zero.
- R6: A write with bit 31 clear, or a write to any other offset, leaves the count unchanged.
- R7: When a clear write and an active count fall in the same cycle, the clear wins. Counting then resumes from zero in the next cycle if the pin is still low.
- R8: A read of offset 0x50 returns the count in bits CNT_W−1:0 (28:0 by default) with every higher bit zero. A read of any other offset returns all zeros.
- R9: Every read request gives exactly one response, with rsp_valid high in the next cycle, and the response carries the count as it stood when the request was taken. Writes produce no response.
- R10: The power-on reset sets the count to zero and leaves rsp_valid low, whatever the state of the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_n | input | 1 | Measured external reset pin, active low, asynchronous |
| req_valid | input | 1 | Register request strobe, one cycle per request |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | ADDR_W | Byte offset of the request within the register window |
| req_wdata | input | DATA_W | Write data; bit 31 is the clear bit |
| rsp_valid | output | 1 | Read response valid, one cycle after the read request |
| rsp_rdata | output | DATA_W | Read response data |

## Verification
The bench holds the pin low for presses of several lengths. A short press and a longer one separate a count that really tracks duration from one stuck at a constant. A second, shorter press after a longer one shows that the count restarts rather than accumulates. A press much longer than the counter range (with a narrow bench width) separates saturation from wraparound. A clear written while the pin is still low separates clear-wins-and-resume from plain clearing. Writes without the clear bit and writes to a wrong offset, followed by reads, show from the ports that they leave the count alone.

// File: rtl/pin_hold_pkg.sv
package pin_hold_pkg;
  // Default geometry of the measurement register
  localparam int unsigned CNT_W_DEF   = 29;
  localparam int unsigned DATA_W_DEF  = 32;
  localparam int unsigned ADDR_W_DEF  = 8;
  localparam int unsigned CLR_BIT_DEF = 31;
  localparam int unsigned SYNC_STAGES = 2;
  localparam logic [ADDR_W_DEF-1:0] REG_OFS_DEF = 8'h50;
endpackage

// File: rtl/phm_sync.sv
module phm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain_q[0] <= 1'b1;   // idle level: pin released
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/phm_counter.sv
module phm_counter #(
  parameter int unsigned CNT_W = 29
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             pin_low,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;
  logic             prev_low_q;
  logic             start;

  // a fresh falling edge of the synchronized pin begins a new measurement
  assign start = pin_low & ~prev_low_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      count_q    <= '0;
      prev_low_q <= 1'b0;
    end else begin
      prev_low_q <= pin_low;
      if (clr)                              count_q <= '0;   // clear has priority
      else if (start)                       count_q <= CNT_W'(1);
      else if (pin_low && count_q != CNT_MAX) count_q <= count_q + 1'b1;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/phm_regport.sv
module phm_regport #(
  parameter int unsigned CNT_W   = 29,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned CLR_BIT = 31,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'h50
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  count,
  output logic              clr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic hit;
  logic rd_req;
  logic wdata_unused;

  assign hit          = (req_addr == REG_OFS);
  assign rd_req       = req_valid & ~req_write;
  assign clr          = req_valid & req_write & hit & req_wdata[CLR_BIT];
  assign wdata_unused = ^req_wdata;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= hit ? {{PAD_W{1'b0}}, count} : '0;
    end
  end
endmodule

// File: rtl/pin_hold_meter.sv
module pin_hold_meter
  import pin_hold_pkg::*;
#(
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned DATA_W  = DATA_W_DEF,
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned CLR_BIT = CLR_BIT_DEF,
  parameter logic [ADDR_W-1:0] REG_OFS = REG_OFS_DEF
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              pin_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic             pin_sync;
  logic             pin_low;
  logic             clr_hit;
  logic [CNT_W-1:0] count_q;

  phm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_n(por_n), .async_in(pin_n), .sync_out(pin_sync)
  );

  assign pin_low = ~pin_sync;

  phm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .por_n(por_n), .pin_low(pin_low), .clr(clr_hit), .count(count_q)
  );

  phm_regport #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CLR_BIT(CLR_BIT), .REG_OFS(REG_OFS)
  ) u_reg (
    .clk(clk), .por_n(por_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .count(count_q), .clr(clr_hit),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/pin_hold_meter_chk.sv
module pin_hold_meter_chk #(
  parameter int unsigned CNT_W  = 29,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              por_n,
  input logic              pin_low,
  input logic              clr,
  input logic [CNT_W-1:0]  cnt,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  a_r1_step_one: assert property (@(posedge clk) disable iff (!por_n)
    (pin_low && !clr && cnt != CMAX) |=> (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == CNT_W'(1)));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!por_n)
    (!pin_low && !clr) |=> $stable(cnt));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!por_n)
    (cnt == CMAX && !clr) |=> (cnt == CMAX || cnt == CNT_W'(1)));

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!por_n)
    clr |=> (cnt == '0));

  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!por_n)
    rsp_valid |-> (rsp_rdata[DATA_W-1:CNT_W] == '0));

  a_r9_read_resp: assert property (@(posedge clk) disable iff (!por_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r9_no_write_resp: assert property (@(posedge clk) disable iff (!por_n)
    (!req_valid || req_write) |=> !rsp_valid);
endmodule

bind pin_hold_meter pin_hold_meter_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .por_n(por_n), .pin_low(pin_low), .clr(clr_hit), .cnt(count_q),
  .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
);

// File: tb/tb_pin_hold_meter.sv
module tb_pin_hold_meter;
  localparam int unsigned CW = 6;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;
  localparam logic [AW-1:0] OFS = 8'h50;
  localparam logic [DW-1:0] SATV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic pin_n = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  pin_hold_meter #(.CNT_W(CW), .DATA_W(DW), .ADDR_W(AW), .REG_OFS(OFS)) dut (
    .clk(clk), .por_n(por_n), .pin_n(pin_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // monitor: pops the scoreboard when a response appears
  always @(negedge clk) begin
    if (por_n && rsp_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9: unexpected response data=%h expected no response", rsp_rdata);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: read data actual=%0d expected=%0d", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9: no response one cycle after read, actual pending=%0d expected=0",
               exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // pin seen low on exactly len rising edges, then settle past the synchronizer
  task automatic press(input int len);
    @(negedge clk);
    pin_n = 1'b0;
    repeat (len) @(negedge clk);
    pin_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    n_checks++;                                  // R10 reset state
    if (rsp_valid !== 1'b0) begin
      n_fail++; $display("FAIL R10: rsp_valid in reset actual=%b expected=0", rsp_valid);
    end
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read(OFS, 0, "R10");                      // count zero after reset

    press(10);
    do_read(OFS, 10, "R1");                      // ten low cycles
    repeat (8) @(negedge clk);
    do_read(OFS, 10, "R2");                      // retained after release

    press(5);
    do_read(OFS, 5, "R4");                       // restart, not accumulate

    do_write(OFS, 32'h7FFF_FFFF);                // bit 31 clear
    do_read(OFS, 5, "R6");
    do_write(8'h54, 32'h8000_0000);              // wrong offset
    do_read(OFS, 5, "R6");
    do_read(8'h54, 0, "R8");                     // other offset reads zero

    do_write(OFS, 32'h8000_0000);
    do_read(OFS, 0, "R5");

    press(100);
    do_read(OFS, SATV, "R3");                    // saturates at 63
    repeat (5) @(negedge clk);
    do_read(OFS, SATV, "R8");                    // upper bits zero

    // clear while the pin is low: expect M+2 counts after the clear edge
    @(negedge clk);
    pin_n = 1'b0;
    repeat (20) @(negedge clk);
    do_write(OFS, 32'h8000_0000);
    repeat (7) @(negedge clk);
    pin_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(OFS, 9, "R7");

    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read(OFS, 0, "R10");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule